// File: doc/BRIEF.md
# Result Bus Reservation Shift Register

This block schedules a single shared result bus for a set of parallel functional units whose latencies are fixed. When an instruction asks to issue with a latency of L clocks, the block claims a slot in a shift register. The instruction is considered to occupy stage L in its issue cycle. Each slot moves one stage toward stage 1 every clock. A slot leaving stage 1 becomes the bus control for the following clock. That control carries the producing unit, the destination register and the instruction's program counter. If the claimed stage is already taken, the request is stalled and tried again on the next clock.

An ordering input selects between two modes. In free mode, short instructions may overtake long ones. In ordered mode, an issuing instruction also fills every free stage below its own with padding slots. Padding slots never write anything, so results reach the bus in issue order.

A store issues a placeholder slot instead of a register write. When the placeholder reaches the bus, the block pulses a release that lets the store commit to memory. The completing unit may flag an unmasked exception while its result is on the bus. When it does, the block records that result's program counter, suppresses every register write and store release from then on, and refuses all further issue.

Top module: `resbus_sched`

## Requirements
- R1: After reset, bus_vld, bus_we, st_release and exc_hold are 0 and exc_pc is 0. A request with a legal latency is accepted (iss_stall = 0).
- R2: An instruction accepted in cycle c with latency L (1 to N_STAGES) appears on the bus in cycle c+L. In that cycle bus_vld = 1, bus_fu, bus_dst and bus_pc equal the values given at issue, and, for a write, bus_we = 1 unless an exception is present.
- R3: In free mode (inorder_en = 0), a request stalls only while an earlier instruction sits in the stage equal to its latency. A stalled request is accepted on the first clock that stage is free. A shorter instruction issued later may reach the bus earlier.
- R4: In ordered mode (inorder_en = 1), an earlier instruction makes every stage up to its own position busy. Example: a latency-6 issue followed on the next clock by a latency-2 request is accepted exactly 5 clocks after the first. Results reach the bus in issue order.
- R5: Padding slots created in ordered mode never raise bus_vld, bus_we or st_release when they reach the bus.
- R6: A request with latency 0 or latency above N_STAGES always stalls and puts nothing on the bus.
- R7: A store (iss_store = 1) accepted in cycle c with latency L gives, in cycle c+L, bus_vld = 1, bus_we = 0 and st_release = 1. In other cycles st_release stays 0.
- R8: If exc_in = 1 while bus_vld = 1 and exc_hold = 0, that result's bus_we and st_release are 0 in the same cycle. From the next cycle on, exc_hold = 1 and exc_pc holds that result's bus_pc. Both stay held.
- R9: While exc_hold = 1, bus_we and st_release stay 0 for every later result, and every issue request stalls. A request made in the exception cycle itself is still accepted, and its result is cancelled when it arrives.
- R10: exc_in is ignored while bus_vld = 0. It sets no hold and changes no later write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inorder_en | input | 1 | 1 selects ordered mode with padding |
| iss_req | input | 1 | Instruction asks to issue this cycle |
| iss_lat | input | LAT_W | Latency in clocks, legal range 1 to N_STAGES |
| iss_store | input | 1 | 1 marks a store placeholder instead of a register write |
| iss_fu | input | FU_W | Producing functional unit |
| iss_dst | input | DST_W | Destination register |
| iss_pc | input | PC_W | Program counter of the instruction |
| exc_in | input | 1 | Unmasked exception flag for the result now on the bus |
| iss_stall | output | 1 | Request not accepted this cycle |
| bus_vld | output | 1 | A real result (write or store) owns the bus this cycle |
| bus_fu | output | FU_W | Unit that drives the bus |
| bus_dst | output | DST_W | Destination register of the bus result |
| bus_pc | output | PC_W | Program counter of the bus result |
| bus_we | output | 1 | Register write enable |
| st_release | output | 1 | Store may commit to memory |
| exc_hold | output | 1 | An exception has been taken; the block is halted |
| exc_pc | output | PC_W | Saved program counter of the faulting result |

## Verification
An exception on the bus can coincide with a new issue. It can also fall in the same cycle as a result that would otherwise write. The bench provokes this by flagging an exception on a latency-2 write in the very cycle a latency-1 write is requested. The request must be accepted, and the faulting write must not be enabled. One clock later, the latency-1 result appears with its write suppressed. A pending store must reach the bus without a release, and the saved program counter must stay that of the first faulting result. Separately, a sweep over both modes, every pair of latencies and several issue gaps predicts the stall cycles and the bus cycle of each result arithmetically.

// File: rtl/resbus_pkg.sv
package resbus_pkg;

    parameter int FU_W  = 2;
    parameter int DST_W = 3;
    parameter int PC_W  = 8;

    typedef enum logic [1:0] {
        K_EMPTY = 2'd0,
        K_NULL  = 2'd1,
        K_WRITE = 2'd2,
        K_STORE = 2'd3
    } slot_kind_e;

    typedef struct packed {
        slot_kind_e             kind;
        logic [FU_W-1:0]        fu;
        logic [DST_W-1:0]       dst;
        logic [PC_W-1:0]        pc;
    } slot_t;

endpackage

// File: rtl/resbus_issue_gate.sv
module resbus_issue_gate
    import resbus_pkg::*;
#(
    parameter int N     = 6,
    parameter int LAT_W = 3
) (
    input  logic             req,
    input  logic [LAT_W-1:0] lat,
    input  logic             inorder,
    input  logic             halt,
    input  logic [N-1:0]     occ,
    output logic             fire,
    output logic [N-1:0]     place,
    output logic [N-1:0]     pad
);

    logic lat_ok;
    logic hit;

    always_comb begin
        lat_ok = (lat != '0) && (lat <= LAT_W'(N));
        place  = '0;
        for (int s = 0; s < N; s++) begin
            if (lat_ok && (lat == LAT_W'(s + 1))) place[s] = 1'b1;
        end
        hit  = |(place & occ);
        fire = req && !halt && lat_ok && !hit;
        pad  = '0;
        for (int s = 0; s < N; s++) begin
            if (fire && inorder && (LAT_W'(s + 1) < lat) && !occ[s]) pad[s] = 1'b1;
        end
    end

endmodule

// File: rtl/resbus_slot_chain.sv
module resbus_slot_chain
    import resbus_pkg::*;
#(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fire,
    input  logic [N-1:0] place,
    input  logic [N-1:0] pad,
    input  slot_t        new_slot,
    output logic [N-1:0] occ,
    output slot_t        head
);

    localparam slot_t EMPTY_SLOT = '{kind: K_EMPTY, fu: '0, dst: '0, pc: '0};
    localparam slot_t NULL_SLOT  = '{kind: K_NULL,  fu: '0, dst: '0, pc: '0};

    typedef struct packed {
        slot_t [N-2:0] stg;
    } chain_t;

    chain_t st_q, st_d;
    slot_t  base [N];
    slot_t  eff  [N];

    for (genvar s = 0; s < N; s++) begin : g_stage
        if (s < N - 1) begin : g_reg
            assign base[s] = st_q.stg[s];
        end else begin : g_top
            assign base[s] = EMPTY_SLOT;
        end
        assign occ[s] = (base[s].kind != K_EMPTY);
    end

    always_comb begin
        for (int s = 0; s < N; s++) begin
            eff[s] = base[s];
            if (fire && place[s]) eff[s] = new_slot;
            else if (pad[s])      eff[s] = NULL_SLOT;
        end
        head = eff[0];
        st_d = st_q;
        for (int s = 1; s < N; s++) begin
            st_d.stg[s-1] = eff[s];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/resbus_retire.sv
module resbus_retire
    import resbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  slot_t            head,
    input  logic             exc_in,
    output logic             bus_vld,
    output logic [FU_W-1:0]  bus_fu,
    output logic [DST_W-1:0] bus_dst,
    output logic [PC_W-1:0]  bus_pc,
    output logic             bus_we,
    output logic             st_release,
    output logic             exc_hold,
    output logic [PC_W-1:0]  exc_pc
);

    typedef struct packed {
        slot_t           bus;
        logic            halt;
        logic [PC_W-1:0] epc;
    } ret_t;

    ret_t r_q, r_d;
    logic real_q;
    logic take;

    always_comb begin
        real_q = (r_q.bus.kind == K_WRITE) || (r_q.bus.kind == K_STORE);
        take   = real_q && exc_in && !r_q.halt;
        r_d      = r_q;
        r_d.bus  = head;
        r_d.halt = r_q.halt || take;
        r_d.epc  = take ? r_q.bus.pc : r_q.epc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bus_vld    = real_q;
    assign bus_fu     = r_q.bus.fu;
    assign bus_dst    = r_q.bus.dst;
    assign bus_pc     = r_q.bus.pc;
    assign bus_we     = (r_q.bus.kind == K_WRITE) && !r_q.halt && !exc_in;
    assign st_release = (r_q.bus.kind == K_STORE) && !r_q.halt && !exc_in;
    assign exc_hold   = r_q.halt;
    assign exc_pc     = r_q.epc;

endmodule

// File: rtl/resbus_sched.sv
module resbus_sched
    import resbus_pkg::*;
#(
    parameter int N_STAGES = 6,
    localparam int LAT_W   = $clog2(N_STAGES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inorder_en,
    input  logic             iss_req,
    input  logic [LAT_W-1:0] iss_lat,
    input  logic             iss_store,
    input  logic [FU_W-1:0]  iss_fu,
    input  logic [DST_W-1:0] iss_dst,
    input  logic [PC_W-1:0]  iss_pc,
    input  logic             exc_in,
    output logic             iss_stall,
    output logic             bus_vld,
    output logic [FU_W-1:0]  bus_fu,
    output logic [DST_W-1:0] bus_dst,
    output logic [PC_W-1:0]  bus_pc,
    output logic             bus_we,
    output logic             st_release,
    output logic             exc_hold,
    output logic [PC_W-1:0]  exc_pc
);

    logic [N_STAGES-1:0] occ;
    logic [N_STAGES-1:0] place;
    logic [N_STAGES-1:0] pad;
    logic                fire;
    slot_t               new_slot;
    slot_t               head;

    assign new_slot.kind = iss_store ? K_STORE : K_WRITE;
    assign new_slot.fu   = iss_fu;
    assign new_slot.dst  = iss_dst;
    assign new_slot.pc   = iss_pc;

    resbus_issue_gate #(.N(N_STAGES), .LAT_W(LAT_W)) u_gate (
        .req     (iss_req),
        .lat     (iss_lat),
        .inorder (inorder_en),
        .halt    (exc_hold),
        .occ     (occ),
        .fire    (fire),
        .place   (place),
        .pad     (pad)
    );

    resbus_slot_chain #(.N(N_STAGES)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .place    (place),
        .pad      (pad),
        .new_slot (new_slot),
        .occ      (occ),
        .head     (head)
    );

    resbus_retire u_ret (
        .clk        (clk),
        .rst_n      (rst_n),
        .head       (head),
        .exc_in     (exc_in),
        .bus_vld    (bus_vld),
        .bus_fu     (bus_fu),
        .bus_dst    (bus_dst),
        .bus_pc     (bus_pc),
        .bus_we     (bus_we),
        .st_release (st_release),
        .exc_hold   (exc_hold),
        .exc_pc     (exc_pc)
    );

    assign iss_stall = iss_req && !fire;

endmodule

// File: rtl/resbus_sched_chk.sv
module resbus_sched_chk
    import resbus_pkg::*;
#(
    parameter int N_STAGES = 6,
    localparam int LAT_W   = $clog2(N_STAGES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             iss_req,
    input logic [LAT_W-1:0] iss_lat,
    input logic             iss_store,
    input logic [DST_W-1:0] iss_dst,
    input logic [PC_W-1:0]  iss_pc,
    input logic             exc_in,
    input logic             iss_stall,
    input logic             bus_vld,
    input logic [DST_W-1:0] bus_dst,
    input logic [PC_W-1:0]  bus_pc,
    input logic             bus_we,
    input logic             st_release,
    input logic             exc_hold,
    input logic [PC_W-1:0]  exc_pc
);

    AST_UNIT_LAT_ARRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        iss_req && !iss_stall && !iss_store && (iss_lat == LAT_W'(1))
        |=> bus_vld && (bus_dst == $past(iss_dst)) && (bus_pc == $past(iss_pc))); // R2

    AST_BAD_LAT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        iss_req && ((iss_lat == '0) || (iss_lat > LAT_W'(N_STAGES))) |-> iss_stall); // R6

    AST_EXC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_vld && exc_in && !exc_hold |=> exc_hold && (exc_pc == $past(bus_pc))); // R8

    AST_HOLD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        exc_hold |=> exc_hold && $stable(exc_pc)); // R8

    AST_HALT_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        exc_hold |-> !bus_we && !st_release); // R9

    AST_HALT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        exc_hold && iss_req |-> iss_stall); // R9

    AST_IDLE_EXC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_vld && !exc_hold |=> !exc_hold); // R10

endmodule

bind resbus_sched resbus_sched_chk #(.N_STAGES(N_STAGES)) u_chk (.*);

// File: tb/sim_resbus_sched.sv
`timescale 1ns/1ps
module sim_resbus_sched;
    import resbus_pkg::*;

    localparam int N  = 6;
    localparam int LW = $clog2(N + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             inorder_en, iss_req, iss_store, exc_in;
    logic [LW-1:0]    iss_lat;
    logic [FU_W-1:0]  iss_fu;
    logic [DST_W-1:0] iss_dst;
    logic [PC_W-1:0]  iss_pc;
    logic             iss_stall, bus_vld, bus_we, st_release, exc_hold;
    logic [FU_W-1:0]  bus_fu;
    logic [DST_W-1:0] bus_dst;
    logic [PC_W-1:0]  bus_pc, exc_pc;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    resbus_sched #(.N_STAGES(N)) u0 (.*);

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic idle_in();
        iss_req = 1'b0; iss_lat = '0; iss_store = 1'b0;
        iss_fu = '0; iss_dst = '0; iss_pc = '0; exc_in = 1'b0;
    endtask

    task automatic req(int lat, bit st, int fu, int dst, int pc);
        iss_req = 1'b1; iss_lat = LW'(lat); iss_store = st;
        iss_fu = FU_W'(fu); iss_dst = DST_W'(dst); iss_pc = PC_W'(pc);
    endtask

    task automatic do_reset(bit mode);
        rst_n = 1'b0; inorder_en = mode; idle_in();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        int tb;
        string ctx;
        // R1: reset state
        do_reset(1'b0);
        #1;
        chk("R1", "bus_vld", int'(bus_vld), 0);
        chk("R1", "bus_we", int'(bus_we), 0);
        chk("R1", "st_release", int'(st_release), 0);
        chk("R1", "exc_hold", int'(exc_hold), 0);
        chk("R1", "exc_pc", int'(exc_pc), 0);
        req(3, 0, 1, 1, 1);
        #1;
        chk("R1", "stall", int'(iss_stall), 0);

        // sweep: two instructions, both modes, all latency pairs, several gaps
        for (int mode = 0; mode < 2; mode++) begin
            for (int l1 = 1; l1 <= N; l1++) begin
                for (int l2 = 1; l2 <= N; l2++) begin
                    for (int g = 1; g <= 3; g++) begin
                        if (mode == 1) tb = (g > l1 - l2 + 1) ? g : l1 - l2 + 1;
                        else           tb = (l1 - g == l2) ? g + 1 : g;
                        ctx = $sformatf("m%0d L%0d/L%0d g%0d", mode, l1, l2, g);
                        do_reset(mode[0]);
                        for (int t = 0; t < 16; t++) begin
                            bit va, vb;
                            if (t > 0) @(negedge clk);
                            idle_in();
                            if (t == 0) req(l1, 0, 1, 3, 8'h20);
                            else if (t >= g && t <= tb) req(l2, 0, 2, 5, 8'h21);
                            #1;
                            if (t == 0) chk("R2", {ctx, " first stall"}, int'(iss_stall), 0);
                            else if (t >= g && t <= tb)
                                chk(mode == 1 ? "R4" : "R3", {ctx, " stall"}, int'(iss_stall), int'(t < tb));
                            va = (t == l1);
                            vb = (t == tb + l2);
                            chk((mode == 1 && !va && !vb) ? "R5" : "R2", {ctx, $sformatf(" vld t%0d", t)},
                                int'(bus_vld), int'(va | vb));
                            chk("R2", {ctx, $sformatf(" we t%0d", t)}, int'(bus_we), int'(va | vb));
                            if (va) begin
                                chk("R2", {ctx, " dst A"}, int'(bus_dst), 3);
                                chk("R2", {ctx, " fu A"}, int'(bus_fu), 1);
                                chk("R2", {ctx, " pc A"}, int'(bus_pc), 8'h20);
                            end
                            if (vb) begin
                                chk("R2", {ctx, " dst B"}, int'(bus_dst), 5);
                                chk("R2", {ctx, " pc B"}, int'(bus_pc), 8'h21);
                            end
                        end
                    end
                end
            end
        end

        // R6: illegal latencies
        do_reset(1'b0);
        req(0, 0, 1, 1, 1); #1;
        chk("R6", "lat0 stall", int'(iss_stall), 1);
        req(7, 0, 1, 1, 1); #1;
        chk("R6", "lat7 stall", int'(iss_stall), 1);
        for (int t = 1; t <= 8; t++) begin
            @(negedge clk); idle_in(); #1;
            chk("R6", $sformatf("no bus t%0d", t), int'(bus_vld), 0);
        end

        // R7: store placeholder
        do_reset(1'b0);
        req(3, 1, 2, 4, 8'h33);
        for (int t = 1; t <= 5; t++) begin
            @(negedge clk); idle_in(); #1;
            chk("R7", $sformatf("release t%0d", t), int'(st_release), int'(t == 3));
            chk("R7", $sformatf("vld t%0d", t), int'(bus_vld), int'(t == 3));
            chk("R7", $sformatf("we t%0d", t), int'(bus_we), 0);
            if (t == 3) chk("R7", "pc", int'(bus_pc), 8'h33);
        end

        // R10: exception flag while bus empty
        do_reset(1'b0);
        req(3, 0, 1, 2, 8'h50); exc_in = 1'b1;
        for (int t = 1; t <= 4; t++) begin
            @(negedge clk); idle_in(); exc_in = (t < 3);
            #1;
            chk("R10", $sformatf("hold t%0d", t), int'(exc_hold), 0);
            if (t == 3) chk("R10", "write after idle flag", int'(bus_we), 1);
        end

        // R8, R9: exception coinciding with an issue
        do_reset(1'b0);
        req(2, 0, 1, 1, 8'h40);                  // t0: write, bus at t2
        @(negedge clk); idle_in(); req(4, 1, 2, 6, 8'h41); // t1: store, bus at t5
        #1; chk("R9", "store accepted", int'(iss_stall), 0);
        @(negedge clk); idle_in(); req(1, 0, 3, 7, 8'h42); exc_in = 1'b1; // t2
        #1;
        chk("R9", "issue in exception cycle", int'(iss_stall), 0);
        chk("R8", "faulting vld", int'(bus_vld), 1);
        chk("R8", "faulting we", int'(bus_we), 0);
        @(negedge clk); idle_in(); req(1, 0, 1, 1, 8'h43); #1; // t3
        chk("R8", "hold", int'(exc_hold), 1);
        chk("R8", "saved pc", int'(exc_pc), 8'h40);
        chk("R9", "later vld", int'(bus_vld), 1);
        chk("R9", "later we", int'(bus_we), 0);
        chk("R9", "stall lat1", int'(iss_stall), 1);
        @(negedge clk); idle_in(); req(2, 0, 1, 1, 8'h44); #1; // t4
        chk("R9", "stall lat2", int'(iss_stall), 1);
        @(negedge clk); idle_in(); exc_in = 1'b1; #1; // t5
        chk("R9", "store vld", int'(bus_vld), 1);
        chk("R9", "store release", int'(st_release), 0);
        @(negedge clk); idle_in(); #1; // t6
        chk("R8", "hold sticky", int'(exc_hold), 1);
        chk("R8", "pc sticky", int'(exc_pc), 8'h40);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(10 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule